// File: doc/BRIEF.md
# AES Key Schedule Generator

This block turns a 128-, 192- or 256-bit AES cipher key into the full array of 32-bit schedule words. It emits one word per clock, with the word's index and a valid strobe. After every fourth word it also presents the completed 128-bit round key and its round number. A single sequential engine covers all three key sizes. It keeps the most recent key-length worth of words in a sliding window and computes the byte substitution in logic, so it needs no stored table.

A controller pulses `start` with the key and the size code applied. The engine then runs without interruption and streams 44, 52 or 60 words. It raises `done` together with the last word. A round-key consumer, for example an iterative cipher core filling a key store, takes `round_key` whenever `round_vld` is high.

The controller has three named states:
- **KX_IDLE**: after reset.
- **KX_RUN**: one word is emitted per cycle.
- **KX_FIN**: the schedule is complete and `done` is held high.

The transitions are:
- **IDLE→RUN**: a start is accepted.
- **RUN→FIN**: the final word is emitted.
- **FIN→RUN**: a new start is accepted.
- **RUN** ignores `start`.

Top module: `key_expander`

## Requirements
- R1: `key_size` selects the key length. Code 2'b00 selects 128 bits (Nk=4, 44 words). Code 2'b01 selects 192 bits (Nk=6, 52 words). Code 2'b10 selects 256 bits (Nk=8, 60 words). Code 2'b11 behaves as 2'b00.
- R2: A start is accepted on a clock edge. On the next edge word 0 appears with `word_vld` high. Word i follows i cycles later, with `word_idx` rising by one each cycle and no gaps.
- R3: The first Nk words are the key itself. Word j is taken from `key[255-32*j -: 32]`, so shorter keys occupy the upper bits of `key`. The unused lower bits have no effect.
- R4: For i ≥ Nk, word i is W[i-Nk] XOR t. When i mod Nk = 0, t is the key word W[i-1] rotated left by one byte (byte [31:24] moves to [7:0]), passed through the S-box per byte, and XORed with the round constant in bits [31:24]. Otherwise t is W[i-1].
- R5: For 256-bit keys only, when i mod 8 = 4, t is the per-byte S-box of W[i-1], with no rotation and no round constant.
- R6: The round constants run 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. The sequence restarts at 01 with every accepted start.
- R7: `round_vld` pulses for one cycle together with each word whose index is 4r+3. At that point `round_key` = {W[4r], W[4r+1], W[4r+2], W[4r+3]}, with W[4r] in bits [127:96], and `round_num` = r.
- R8: `busy` is high from the cycle after an accepted start until the last word is shown. `done` goes high in the same cycle as the last word and stays high until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored. The word stream, key size and key continue unchanged.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an expansion of `key` |
| key_size | input | 2 | Key length code (see R1) |
| key | input | 256 | Cipher key, left-aligned |
| word_out | output | 32 | Current schedule word |
| word_idx | output | 6 | Index of `word_out` |
| word_vld | output | 1 | `word_out` and `word_idx` are valid |
| round_key | output | 128 | Completed round key |
| round_num | output | 4 | Round number of `round_key` |
| round_vld | output | 1 | `round_key` is valid this cycle |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | Expansion complete |

## Verification
Every word depends on the words before it, so one wrong window entry, round constant or position counter corrupts the first word that uses it. It then corrupts every word that follows. The bench compares `word_out` on every cycle, which exposes such a fault in the very cycle the faulty word is emitted. A position counter that drifts out of step with the key length shows up at the first boundary where a substitution is applied or skipped in error. This can be as early as word Nk. A round-constant fault shows up at the second substitution step. The published final words of the three standard vectors serve as an independent cross-check on the bench's own model.

// File: rtl/kx_pkg.sv
package kx_pkg;

    localparam int WORD_W = 32;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p = p ^ x;
            x = xtime(x);
        end
        return p;
    endfunction

    // a^254 by repeated squaring: the product of a^2 .. a^128; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = a;
        acc = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return acc;
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    // number of key words for a key_size code
    function automatic logic [3:0] nk_of(input logic [1:0] code);
        logic [3:0] n;
        unique case (code)
            2'b01:   n = 4'd6;
            2'b10:   n = 4'd8;
            default: n = 4'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/kx_subword.sv
module kx_subword #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = kx_pkg::sbox(din[8*b +: 8]);
    end
endmodule

// File: rtl/kx_fsm.sv
module kx_fsm #(
    parameter int IDX_W = 6,
    parameter int NK_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       key_size,
    output logic             load,
    output logic             step,
    output logic             from_key,
    output logic             g_step,
    output logic             sub_only,
    output logic [NK_W-1:0]  nk,
    output logic [IDX_W-1:0] idx,
    output logic [7:0]       rcon,
    output logic             busy,
    output logic             done
);
    import kx_pkg::*;

    typedef enum logic [1:0] {KX_IDLE, KX_RUN, KX_FIN} kx_state_e;

    kx_state_e        state_q, state_d;
    logic [IDX_W-1:0] i_q;
    logic [2:0]       pos_q;
    logic [NK_W-1:0]  nk_q;
    logic [7:0]       rcon_q;
    logic [IDX_W-1:0] total;
    logic             last;

    assign total = IDX_W'({nk_q, 2'b00}) + IDX_W'(28);
    assign last  = (i_q == total - IDX_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KX_IDLE: if (start) state_d = KX_RUN;
            KX_RUN:  if (last)  state_d = KX_FIN;
            KX_FIN:  if (start) state_d = KX_RUN;
            default: state_d = KX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load     = start && (state_q != KX_RUN);
        step     = (state_q == KX_RUN);
        busy     = (state_q == KX_RUN);
        done     = (state_q == KX_FIN);
        from_key = (i_q < IDX_W'(nk_q));
        g_step   = !from_key && (pos_q == 3'd0);
        sub_only = !from_key && (nk_q == NK_W'(8)) && (pos_q == 3'd4);
        nk       = nk_q;
        idx      = i_q;
        rcon     = rcon_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q    <= '0;
            pos_q  <= '0;
            nk_q   <= NK_W'(4);
            rcon_q <= 8'h01;
        end else if (load) begin
            i_q    <= '0;
            pos_q  <= '0;
            nk_q   <= nk_of(key_size);
            rcon_q <= 8'h01;
        end else if (step) begin
            i_q   <= i_q + IDX_W'(1);
            pos_q <= ({1'b0, pos_q} == nk_q - NK_W'(1)) ? 3'd0 : pos_q + 3'd1;
            if (g_step) rcon_q <= xtime(rcon_q);
        end
    end

    // R9: a run is never cut short by a new start
    a_r9_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KX_RUN && !last) |=> (state_q == KX_RUN));

    // R6: every accepted start begins the constant sequence at 01
    a_r6_rcon_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rcon_q == 8'h01 && i_q == '0));

    // R1: the key length latched for a run is one of the three legal values
    a_r1_nk_legal: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (nk_q == NK_W'(4) || nk_q == NK_W'(6) || nk_q == NK_W'(8)));
endmodule

// File: rtl/kx_datapath.sv
module kx_datapath #(
    parameter int MAX_NK = 8,
    parameter int NK_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       step,
    input  logic                       from_key,
    input  logic                       g_step,
    input  logic                       sub_only,
    input  logic [NK_W-1:0]            nk,
    input  logic [7:0]                 rcon,
    input  logic [32*MAX_NK-1:0]       key,
    output logic [31:0]                new_word
);
    localparam int KEY_W = 32 * MAX_NK;
    localparam int SEL_W = $clog2(MAX_NK);

    logic [KEY_W-1:0] key_q;
    logic [31:0]      win_q [MAX_NK];
    logic [31:0]      prev_w, old_w, sub_in, sub_out, temp;
    logic [SEL_W-1:0] old_sel;

    assign prev_w  = win_q[MAX_NK-1];
    assign old_sel = SEL_W'(MAX_NK - int'(nk));
    assign old_w   = win_q[old_sel];
    assign sub_in  = g_step ? {prev_w[23:0], prev_w[31:24]} : prev_w;

    kx_subword #(.BYTES(4)) u_sub (
        .din  (sub_in),
        .dout (sub_out)
    );

    always_comb begin
        if (g_step)        temp = sub_out ^ {rcon, 24'h000000};
        else if (sub_only) temp = sub_out;
        else               temp = prev_w;
        new_word = from_key ? key_q[KEY_W-1 -: 32] : (old_w ^ temp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  key_q <= '0;
        else if (load)               key_q <= key;
        else if (step && from_key)   key_q <= {key_q[KEY_W-33:0], 32'h0};
    end

    for (genvar j = 0; j < MAX_NK; j++) begin : g_win
        if (j == MAX_NK - 1) begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    win_q[j] <= '0;
                else if (step) win_q[j] <= new_word;
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    win_q[j] <= '0;
                else if (step) win_q[j] <= win_q[j+1];
            end
        end
    end

    // R5: the substitution-only step never coincides with the rotate-and-constant step
    a_r5_sub_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !(g_step && sub_only));

    // R3: key words are never combined with the substitution path
    a_r3_key_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (step && from_key) |-> !(g_step || sub_only));
endmodule

// File: rtl/key_expander.sv
module key_expander #(
    parameter int MAX_NK = 8,
    parameter int IDX_W  = 6,
    parameter int RND_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           key_size,
    input  logic [32*MAX_NK-1:0] key,
    output logic [31:0]          word_out,
    output logic [IDX_W-1:0]     word_idx,
    output logic                 word_vld,
    output logic [127:0]         round_key,
    output logic [RND_W-1:0]     round_num,
    output logic                 round_vld,
    output logic                 busy,
    output logic                 done
);
    localparam int NK_W     = 4;
    localparam int LAST_IDX = 4 * MAX_NK + 27;

    logic             load, step, from_key, g_step, sub_only;
    logic [NK_W-1:0]  nk;
    logic [IDX_W-1:0] idx;
    logic [7:0]       rcon;
    logic [31:0]      new_word;
    logic [95:0]      acc_q;

    kx_fsm #(.IDX_W(IDX_W), .NK_W(NK_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .key_size (key_size),
        .load     (load),
        .step     (step),
        .from_key (from_key),
        .g_step   (g_step),
        .sub_only (sub_only),
        .nk       (nk),
        .idx      (idx),
        .rcon     (rcon),
        .busy     (busy),
        .done     (done)
    );

    kx_datapath #(.MAX_NK(MAX_NK), .NK_W(NK_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .from_key (from_key),
        .g_step   (g_step),
        .sub_only (sub_only),
        .nk       (nk),
        .rcon     (rcon),
        .key      (key),
        .new_word (new_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out  <= '0;
            word_idx  <= '0;
            word_vld  <= 1'b0;
            acc_q     <= '0;
            round_key <= '0;
            round_num <= '0;
            round_vld <= 1'b0;
        end else if (step) begin
            word_out <= new_word;
            word_idx <= idx;
            word_vld <= 1'b1;
            acc_q    <= {acc_q[63:0], new_word};
            if (idx[1:0] == 2'b11) begin
                round_key <= {acc_q, new_word};
                round_num <= RND_W'(idx[IDX_W-1:2]);
                round_vld <= 1'b1;
            end else begin
                round_vld <= 1'b0;
            end
        end else begin
            word_vld  <= 1'b0;
            round_vld <= 1'b0;
        end
    end

    // R2: consecutive valid words carry consecutive indices
    a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && $past(word_vld)) |-> (word_idx == $past(word_idx) + IDX_W'(1)));

    // R1: no index beyond the longest schedule
    a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (word_idx <= IDX_W'(LAST_IDX)));

    // R7: a round key only accompanies the fourth word of a group, and ends with it
    a_r7_rkey_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        round_vld |-> (word_vld && word_idx[1:0] == 2'b11));

    a_r7_rkey_tail: assert property (@(posedge clk) disable iff (!rst_n)
        round_vld |-> (round_key[31:0] == word_out));

    // R8: completion coincides with the final word and final round key
    a_r8_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (word_vld && round_vld && !busy));
endmodule

// File: tb/key_expander_bench.sv
`timescale 1ns/1ps
module key_expander_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   key_size = 2'b00;
    logic [255:0] key = '0;
    logic [31:0]  word_out;
    logic [5:0]   word_idx;
    logic         word_vld;
    logic [127:0] round_key;
    logic [3:0]   round_num;
    logic         round_vld;
    logic         busy;
    logic         done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [31:0] exp_w [60];

    always #2.5 clk = ~clk;

    key_expander u_key_expander (
        .clk(clk), .rst_n(rst_n), .start(start), .key_size(key_size), .key(key),
        .word_out(word_out), .word_idx(word_idx), .word_vld(word_vld),
        .round_key(round_key), .round_num(round_num), .round_vld(round_vld),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // reference arithmetic: inverse by exhaustive search, affine bit by bit
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        int p = 0;
        int x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p = p ^ x;
            x = x << 1;
            if (x > 255) x = x ^ 'h11b;
        end
        return 8'(p);
    endfunction

    function automatic logic [7:0] ref_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        logic [7:0] r;
        logic [7:0] c = 8'h63;
        if (a != 0)
            for (int b = 1; b < 256; b++)
                if (ref_mul(a, 8'(b)) == 8'h01) inv = 8'(b);
        for (int i = 0; i < 8; i++)
            r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return r;
    endfunction

    function automatic logic [31:0] ref_subw(input logic [31:0] w);
        return {ref_sbox(w[31:24]), ref_sbox(w[23:16]), ref_sbox(w[15:8]), ref_sbox(w[7:0])};
    endfunction

    task automatic build(input logic [255:0] k, input int nk);
        logic [7:0] rcl [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
        logic [31:0] t;
        for (int i = 0; i < nk; i++) exp_w[i] = k[255 - 32*i -: 32];
        for (int i = nk; i < 4*nk + 28; i++) begin
            t = exp_w[i-1];
            if (i % nk == 0) begin
                t = ref_subw({t[23:0], t[31:24]}) ^ {rcl[i/nk - 1], 24'h0};
            end else if (nk == 8 && i % 8 == 4) begin
                t = ref_subw(t);
            end
            exp_w[i] = exp_w[i-nk] ^ t;
        end
    endtask

    // inj < 0: no start during the run; known = 0: no published final word
    task automatic run_case(input logic [255:0] k, input logic [1:0] sel, input int inj,
                            input logic [31:0] known);
        int nk = (sel == 2'b10) ? 8 : (sel == 2'b01) ? 6 : 4;
        int n  = 4*nk + 28;
        build(k, nk);
        @(negedge clk);
        key = k; key_size = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && word_vld == 1'b0 && done == 1'b0, "R8 busy after start",
            {busy, word_vld, done}, 3'b100);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            chk(word_vld == 1'b1 && word_idx == 6'(i), "R2 index sequence", word_idx, i);
            chk(word_out == exp_w[i], (i < nk) ? "R3 key word" :
                ((i % nk == 0) ? "R4/R6 rotated word" :
                 ((nk == 8 && i % 8 == 4) ? "R5 sub-only word" : "R4 xor word")),
                word_out, exp_w[i]);
            if (i % 4 == 3) begin
                chk(round_vld == 1'b1 && round_num == 4'(i/4) &&
                    round_key == {exp_w[i-3], exp_w[i-2], exp_w[i-1], exp_w[i]},
                    "R7 round key", round_key,
                    {exp_w[i-3], exp_w[i-2], exp_w[i-1], exp_w[i]});
            end else begin
                chk(round_vld == 1'b0, "R7 no round key", round_vld, 0);
            end
            chk(done == (i == n-1) && busy == (i != n-1), "R8 busy/done",
                {busy, done}, {i != n-1, i == n-1});
            if (i == inj) begin
                start = 1'b1; key = ~k; key_size = ~sel;   // R9: must be ignored
            end
        end
        if (known != 32'h0)
            chk(word_out == known, "R1/R4/R5 published final word", word_out, known);
        @(negedge clk);
        chk(word_vld == 1'b0 && round_vld == 1'b0 && done == 1'b1 && busy == 1'b0,
            "R8 hold after finish", {word_vld, round_vld, done, busy}, 4'b0010);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(word_out == 0 && word_idx == 0 && word_vld == 0 && round_key == 0 &&
            round_num == 0 && round_vld == 0 && busy == 0 && done == 0,
            "R10 reset outputs", {word_vld, round_vld, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R10 idle after reset", {busy, done}, 0);

        // R1/R3: 128-bit with junk in the unused low bits
        run_case({128'h2b7e151628aed2a6abf7158809cf4f3c, {4{32'hdeadbeef}}}, 2'b00, -1,
                 32'hb6630ca6);
        // 192-bit
        run_case({192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'hffff0000ffff0000},
                 2'b01, -1, 32'h01002202);
        // 256-bit with a start pulse mid-run (R9)
        run_case(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4,
                 2'b10, 20, 32'h706c631e);
        // R9 repeated on the 128-bit case, from the finished state (restart from KX_FIN)
        run_case({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 2'b00, 7, 32'hb6630ca6);
        // R1: code 2'b11 behaves as 128-bit
        run_case({128'h000102030405060708090a0b0c0d0e0f, 128'h55}, 2'b11, -1, 32'h0);
        // R6: restart of the constants on a new 192-bit key
        run_case({192'hffeeddccbbaa99887766554433221100f0e1d2c3b4a59687, 64'h0},
                 2'b01, 30, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule